// File: doc/BRIEF.md
# Watchdog and Interval Timer with Compare Match

This block counts the overflow strobes of an external prescaler in an 8-bit counter. It compares the count with a 6-bit limit that software writes through a small write port. On a match, the block takes one of two actions, chosen by a mode input. In watchdog mode it sends a one-cycle active-low reset request. In interval mode it sets a sticky interrupt flag. In both modes the counter restarts from zero on a match, so interval mode gives a fixed period of interrupts.

Software guards against runaway code by writing the clear bit often enough. Each such write zeroes the counter before the limit is reached. The clear bit drops back to zero by itself one cycle after the write. A low-power stop indication freezes the count, and counting continues from the frozen value when stop ends. The mode input comes up low after reset, so no reset request can be issued until software selects watchdog mode.

Top module: `wdog_cmp`

## Requirements
- R1: After reset the compare limit is 63, the clear bit is 0 and the counter is 0. `rst_req_no` is 1 and `irq_flag_o` is 0. With the mode input low, the first interrupt therefore comes on the 64th strobe.
- R2: The counter advances by one only on a clock in which `tick_i` is 1 and `stop_i` is 0. In all other cycles it holds its value.
- R3: A hit occurs when an accepted strobe arrives while the count equals {2'b00, limit}. On a hit the counter returns to 0, so hits come every limit+1 strobes. A limit of 0 gives a hit on every strobe.
- R4: When `mode_i` is 0, a hit sets `irq_flag_o` at that clock edge. The flag stays 1 until a clock with `irq_clr_i` = 1. If a hit and a clear fall in the same cycle, the hit wins. In this mode `rst_req_no` stays 1.
- R5: When `mode_i` is 1, a hit drives `rst_req_no` to 0 for exactly the one cycle after the hit edge. The interrupt flag is left unchanged.
- R6: A write with `wr_en_i` = 1 loads the limit from `wr_data_i[5:0]` and the clear bit from `wr_data_i[6]`.
- R7: When `wr_data_i[6]` = 1, the counter is forced to 0 at the write edge and at the following edge. At that second edge the clear bit returns to 0 by itself. A strobe in either cycle is discarded, and counting restarts afterwards.
- R8: When `stop_i` = 1, strobes are ignored and the count is held. After stop ends, counting continues from the held value, with no clear.
- R9: A write with `wr_data_i[6]` = 0 changes the limit and leaves the running count untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaler overflow strobe, one cycle per overflow |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 7 | Write data: [5:0] limit, [6] counter clear |
| mode_i | input | 1 | 1 = reset request on hit, 0 = interrupt flag on hit |
| stop_i | input | 1 | Low-power stop, freezes counting |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| rst_req_no | output | 1 | Active-low reset request, one-cycle pulse |
| irq_flag_o | output | 1 | Sticky interrupt flag |

## Verification
The count is not visible at the ports. Every claim about its value therefore has to be read from when the next hit arrives. The hardest case is showing that stop holds the count rather than clearing it. The bench advances the counter part way, sends strobes while stop is high, then releases stop. It checks that the hit comes after the strobes that were still outstanding, not after a full period. Clear-versus-strobe collisions and limit changes without a clear are tested the same way, by counting the strobes up to the next hit.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned CMP_W   = 6;
  localparam int unsigned CLR_BIT = CMP_W;
  localparam int unsigned WR_W    = CMP_W + 1;
  localparam logic [CMP_W-1:0] CMP_RST = '1;

  typedef enum logic {
    MODE_IRQ   = 1'b0,
    MODE_RESET = 1'b1
  } wdog_mode_e;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg #(
  parameter int unsigned CMP_W = wdog_pkg::CMP_W,
  parameter logic [CMP_W-1:0] CMP_RST = wdog_pkg::CMP_RST,
  localparam int unsigned WR_W = CMP_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WR_W-1:0]  wr_data_i,
  output logic [CMP_W-1:0] cmp_o,
  output logic             clr_now_o
);
  logic [CMP_W-1:0] cmp_q, cmp_d;
  logic             clr_q, clr_d;
  logic             cmp_en;

  always_comb begin
    cmp_en = wr_en_i;
    cmp_d  = wr_data_i[CMP_W-1:0];
    clr_d  = wr_en_i & wr_data_i[CMP_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= CMP_RST;
    end else if (cmp_en) begin
      cmp_q <= cmp_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q <= 1'b0;
    end else begin
      clr_q <= clr_d;
    end
  end

  assign cmp_o     = cmp_q;
  assign clr_now_o = clr_d | clr_q;

  assert_clr_selfclear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_q && !wr_en_i) |=> !clr_q);
  assert_limit_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (cmp_o == $past(wr_data_i[CMP_W-1:0])));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = wdog_pkg::CNT_W,
  parameter int unsigned CMP_W = wdog_pkg::CMP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             stop_i,
  input  logic             clr_now_i,
  input  logic [CMP_W-1:0] cmp_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cmp_ext;
  logic             tick_ok;
  logic             cnt_en;

  generate
    if (CNT_W > CMP_W) begin : g_ext
      assign cmp_ext = {{(CNT_W-CMP_W){1'b0}}, cmp_i};
    end else begin : g_trunc
      assign cmp_ext = cmp_i[CNT_W-1:0];
    end
  endgenerate

  always_comb begin
    tick_ok = tick_i & ~stop_i & ~clr_now_i;
    hit_o   = tick_ok & (cnt_q == cmp_ext);
    cnt_en  = clr_now_i | tick_ok;
    if (clr_now_i || hit_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assert_clear_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_now_i |=> (cnt_q == '0));
  assert_stop_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !clr_now_i) |=> $stable(cnt_q));
  assert_idle_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_now_i) |=> $stable(cnt_q));
  assert_hit_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_action.sv
module wdog_action (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic mode_i,
  input  logic irq_clr_i,
  output logic rst_req_no,
  output logic irq_flag_o
);
  import wdog_pkg::*;
  wdog_mode_e mode;
  logic rst_q, rst_d;
  logic flag_q, flag_d;

  always_comb begin
    mode   = wdog_mode_e'(mode_i);
    rst_d  = hit_i & (mode == MODE_RESET);
    flag_d = (hit_i & (mode == MODE_IRQ)) | (flag_q & ~irq_clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      rst_q  <= rst_d;
      flag_q <= flag_d;
    end
  end

  assign rst_req_no = ~rst_q;
  assign irq_flag_o = flag_q;

  assert_reset_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && mode_i) |=> !rst_req_no);
  assert_no_reset_irqmode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> rst_req_no);
  assert_flag_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !mode_i) |=> irq_flag_o);
  assert_flag_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flag_o && !irq_clr_i) |=> irq_flag_o);
endmodule

// File: rtl/wdog_cmp.sv
module wdog_cmp #(
  parameter int unsigned CNT_W = wdog_pkg::CNT_W,
  parameter int unsigned CMP_W = wdog_pkg::CMP_W,
  localparam int unsigned WR_W = CMP_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            wr_en_i,
  input  logic [WR_W-1:0] wr_data_i,
  input  logic            mode_i,
  input  logic            stop_i,
  input  logic            irq_clr_i,
  output logic            rst_req_no,
  output logic            irq_flag_o
);
  logic [CMP_W-1:0] cmp;
  logic             clr_now;
  logic             hit;

  wdog_ctrl_reg #(.CMP_W(CMP_W), .CMP_RST({CMP_W{1'b1}})) i_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .cmp_o(cmp), .clr_now_o(clr_now)
  );

  wdog_counter #(.CNT_W(CNT_W), .CMP_W(CMP_W)) i_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .stop_i(stop_i),
    .clr_now_i(clr_now), .cmp_i(cmp), .hit_o(hit)
  );

  wdog_action i_act (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .mode_i(mode_i),
    .irq_clr_i(irq_clr_i), .rst_req_no(rst_req_no), .irq_flag_o(irq_flag_o)
  );
endmodule

// File: tb/test_wdog_cmp.sv
module test_wdog_cmp;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [6:0] wr_data_i = '0;
  logic       mode_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       irq_clr_i = 1'b0;
  logic       rst_req_no;
  logic       irq_flag_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  wdog_cmp i_wdog_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .mode_i(mode_i), .stop_i(stop_i), .irq_clr_i(irq_clr_i),
    .rst_req_no(rst_req_no), .irq_flag_o(irq_flag_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      step();
      tick_i = 1'b0;
    end
  endtask

  task automatic wr(input logic clr, input logic [5:0] lim);
    wr_en_i = 1'b1;
    wr_data_i = {clr, lim};
    step();
    wr_en_i = 1'b0;
    step();
  endtask

  task automatic clear_flag();
    irq_clr_i = 1'b1;
    step();
    irq_clr_i = 1'b0;
  endtask

  task automatic t_reset_default();
    chk("R1 rst_req_no after reset", rst_req_no, 1);
    chk("R1 flag after reset", irq_flag_o, 0);
    tick(63);
    chk("R1 no flag before 64th strobe", irq_flag_o, 0);
    tick(1);
    chk("R1 flag on 64th strobe", irq_flag_o, 1);
    chk("R4 no reset in irq mode", rst_req_no, 1);
    clear_flag();
  endtask

  task automatic t_interval();
    wr(1'b1, 6'd3);
    tick(3);
    chk("R3 no hit before limit+1", irq_flag_o, 0);
    tick(1);
    chk("R3 hit at limit+1", irq_flag_o, 1);
    step(); step();
    chk("R4 flag sticky", irq_flag_o, 1);
    clear_flag();
    chk("R4 flag cleared", irq_flag_o, 0);
    tick(3);
    chk("R3 second period not early", irq_flag_o, 0);
    irq_clr_i = 1'b1;
    tick(1);
    irq_clr_i = 1'b0;
    chk("R4 hit beats clear", irq_flag_o, 1);
    clear_flag();
    wr(1'b1, 6'd0);
    tick(1);
    chk("R3 limit 0 hits every strobe", irq_flag_o, 1);
    clear_flag();
    tick(1);
    chk("R3 limit 0 hits again", irq_flag_o, 1);
    clear_flag();
  endtask

  task automatic t_reset_mode();
    wr(1'b1, 6'd2);
    mode_i = 1'b1;
    tick(2);
    chk("R5 no request before hit", rst_req_no, 1);
    tick(1);
    chk("R5 request low after hit", rst_req_no, 0);
    chk("R5 flag untouched", irq_flag_o, 0);
    step();
    chk("R5 request one cycle only", rst_req_no, 1);
    mode_i = 1'b0;
  endtask

  task automatic t_clear_bit();
    wr(1'b1, 6'd3);
    tick(3);
    wr(1'b1, 6'd3);
    tick(3);
    chk("R7 clear restarts count", irq_flag_o, 0);
    tick(1);
    chk("R7 full period after clear", irq_flag_o, 1);
    clear_flag();
    tick(2);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_data_i = {1'b1, 6'd3};
    step();
    wr_en_i = 1'b0;
    step();
    tick_i = 1'b0;
    tick(3);
    chk("R7 strobes during clear discarded", irq_flag_o, 0);
    tick(1);
    chk("R7 hit after clear collision", irq_flag_o, 1);
    clear_flag();
  endtask

  task automatic t_stop();
    wr(1'b1, 6'd3);
    tick(2);
    stop_i = 1'b1;
    tick(5);
    chk("R8 no hit while stopped", irq_flag_o, 0);
    stop_i = 1'b0;
    tick(1);
    chk("R8 count held, not early", irq_flag_o, 0);
    tick(1);
    chk("R8 resumes from held value", irq_flag_o, 1);
    clear_flag();
    step();
    chk("R2 idle cycles no hit", irq_flag_o, 0);
  endtask

  task automatic t_limit_change();
    wr(1'b1, 6'd5);
    tick(2);
    wr(1'b0, 6'd3);
    tick(1);
    chk("R9 count kept over limit write", irq_flag_o, 0);
    tick(1);
    chk("R9 hit at new limit", irq_flag_o, 1);
    chk("R6 limit field loaded", irq_flag_o, 1);
    clear_flag();
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    t_reset_default();
    t_interval();
    t_reset_mode();
    t_clear_bit();
    t_stop();
    t_limit_change();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule